// File: doc/BRIEF.md
# Power-Fail Chip-Enable Guard

This block sits between a host's active-low memory chip-enable and a static RAM. While the supply is healthy it passes the chip-enable straight through. A synchronous power-fail flag from an external comparator starts protection. If no access is active at that moment, the RAM is blocked at once. If an access is active, the access may run on until the host releases chip-enable or a bounded grace window ends, whichever comes first. After that the RAM stays blocked.

Once the flag clears, the block keeps the RAM blocked for a recovery interval, measured in clock cycles. Only then does the output follow the host again. A status output is high in every cycle in which the guard, and not the host, controls the output. The analog comparison, the output levels and the supply switching are handled elsewhere.

Top module: `pwr_fail_ce_gate`

## Requirements
- R1: While the guard is idle (supply good, no recovery pending), `sram_ce_n` equals `host_ce_n` in the same cycle and `guard_active` is 0.
- R2: If `pfail` is sampled high at a clock edge while idle and `host_ce_n` is 1, `sram_ce_n` is 1 and `guard_active` is 1 from the next cycle on, whatever `host_ce_n` does afterwards.
- R3: If `pfail` is sampled high while idle and `host_ce_n` is 0, `guard_active` rises in the next cycle and `sram_ce_n` keeps following `host_ce_n` (low) during the grace window.
- R4: Once `host_ce_n` is 1 while `guard_active` is 1, `sram_ce_n` is 1 from that cycle until protection ends, even if `host_ce_n` returns to 0.
- R5: The grace window lasts at most `DEFER_CYC` cycles after the detecting edge. If `host_ce_n` is still 0 then, `sram_ce_n` is forced to 1.
- R6: When `pfail` is first sampled low after a failure, with the grace window over, `sram_ce_n` stays 1 and `guard_active` stays 1 for `REC_CYC` further cycles. After that both follow R1.
- R7: Synchronous active-high `rst` blocks the output (`sram_ce_n` = 1, `guard_active` = 1). With `pfail` low, the block leaves reset through a full recovery interval, so it is idle from `REC_CYC`+1 cycles after release.
- R8: `pfail` reasserting during recovery cancels the interval with the output kept at 1. The next restore starts a fresh `REC_CYC` count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pfail | input | 1 | Supply out of tolerance, already synchronised |
| host_ce_n | input | 1 | Chip-enable from the host, active low |
| sram_ce_n | output | 1 | Gated chip-enable to the RAM, active low |
| guard_active | output | 1 | High while the guard overrides the host |

## Verification
In the idle state the bench runs every 4-bit chip-enable toggle pattern, to tell a true pass-through from a stuck or delayed output. It sweeps the cycle at which the host releases chip-enable across the whole grace window and past its end. This separates an early release, a release on the last grace cycle and a forced timeout. A drop back to low after each release checks that the block stays blocked. Failures are also applied with chip-enable idle for several hold lengths. Power is restored at every offset inside the recovery interval and then failed again, which shows whether the recovery count restarts or runs on from where it was.

// File: rtl/pfg_pkg.sv
`timescale 1ns/1ps
package pfg_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DEFER   = 2'd1,
        ST_BLOCK   = 2'd2,
        ST_RECOVER = 2'd3
    } guard_state_e;

    typedef struct packed {
        logic load;
        logic sel_rec;
        logic dec;
    } tmr_cmd_t;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/pfg_timer.sv
`timescale 1ns/1ps
module pfg_timer
    import pfg_pkg::*;
#(
    parameter int unsigned DEFER_CYC = 375,
    parameter int unsigned REC_CYC   = 500000,
    parameter int unsigned CW        = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_cmd_t      cmd,
    output logic [CW-1:0] cnt,
    output logic          zero
);
    localparam logic [CW-1:0] LD_DEFER = CW'(DEFER_CYC - 1);
    localparam logic [CW-1:0] LD_REC   = CW'(REC_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.load) begin
            cnt <= cmd.sel_rec ? LD_REC : LD_DEFER;
        end else if (cmd.dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.dec && !cmd.load) |-> (cnt != '0));

endmodule

// File: rtl/pfg_seq.sv
`timescale 1ns/1ps
module pfg_seq
    import pfg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         pfail,
    input  logic         host_ce_n,
    input  logic         tmr_zero,
    output guard_state_e state,
    output tmr_cmd_t     cmd
);
    guard_state_e nxt;

    always_comb begin
        nxt = state;
        cmd = '0;
        unique case (state)
            ST_RUN: begin
                if (pfail) begin
                    if (!host_ce_n) begin
                        nxt      = ST_DEFER;
                        cmd.load = 1'b1;
                    end else begin
                        nxt = ST_BLOCK;
                    end
                end
            end
            ST_DEFER: begin
                if (host_ce_n || tmr_zero) nxt = ST_BLOCK;
                else                       cmd.dec = 1'b1;
            end
            ST_BLOCK: begin
                if (!pfail) begin
                    nxt         = ST_RECOVER;
                    cmd.load    = 1'b1;
                    cmd.sel_rec = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (pfail)         nxt = ST_BLOCK;
                else if (tmr_zero) nxt = ST_RUN;
                else               cmd.dec = 1'b1;
            end
            default: nxt = ST_BLOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_BLOCK;
        else     state <= nxt;
    end

    p_idle_fail_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && pfail && host_ce_n) |=> (state == ST_BLOCK));

    p_busy_fail_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && pfail && !host_ce_n) |=> (state == ST_DEFER));

    p_reassert_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOVER && pfail) |=> (state == ST_BLOCK));

endmodule

// File: rtl/pfg_gate.sv
`timescale 1ns/1ps
module pfg_gate
    import pfg_pkg::*;
(
    input  guard_state_e state,
    input  logic         host_ce_n,
    output logic         sram_ce_n,
    output logic         guard_active
);
    logic pass;

    always_comb begin
        pass         = (state == ST_RUN) || (state == ST_DEFER);
        sram_ce_n    = pass ? host_ce_n : 1'b1;
        guard_active = (state != ST_RUN);
    end

endmodule

// File: rtl/pwr_fail_ce_gate.sv
`timescale 1ns/1ps
module pwr_fail_ce_gate
    import pfg_pkg::*;
#(
    parameter int unsigned DEFER_CYC = 375,
    parameter int unsigned REC_CYC   = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic pfail,
    input  logic host_ce_n,
    output logic sram_ce_n,
    output logic guard_active
);
    localparam int unsigned CW = cnt_width(DEFER_CYC, REC_CYC);

    guard_state_e  st;
    tmr_cmd_t      cmd;
    logic [CW-1:0] tmr_cnt;
    logic          tmr_zero;

    pfg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .pfail     (pfail),
        .host_ce_n (host_ce_n),
        .tmr_zero  (tmr_zero),
        .state     (st),
        .cmd       (cmd)
    );

    pfg_timer #(
        .DEFER_CYC (DEFER_CYC),
        .REC_CYC   (REC_CYC),
        .CW        (CW)
    ) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .cnt  (tmr_cnt),
        .zero (tmr_zero)
    );

    pfg_gate u_gate (
        .state        (st),
        .host_ce_n    (host_ce_n),
        .sram_ce_n    (sram_ce_n),
        .guard_active (guard_active)
    );

    p_follow_r1: assert property (@(posedge clk) disable iff (rst)
        !guard_active |-> (sram_ce_n == host_ce_n));

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (guard_active && host_ce_n) |=> (sram_ce_n || !guard_active));

    p_defer_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEFER) |-> (tmr_cnt < CW'(DEFER_CYC)));

    p_recover_load_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BLOCK && !pfail) |=> (st == ST_RECOVER && tmr_cnt == CW'(REC_CYC - 1)));

endmodule

// File: tb/pwr_fail_ce_gate_test.sv
`timescale 1ns/1ps
module pwr_fail_ce_gate_test;
    localparam int D = 4;
    localparam int R = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pfail = 1'b0;
    logic host_ce_n = 1'b1;
    logic sram_ce_n;
    logic guard_active;

    int nchk = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    pwr_fail_ce_gate #(.DEFER_CYC(D), .REC_CYC(R)) uut (
        .clk          (clk),
        .rst          (rst),
        .pfail        (pfail),
        .host_ce_n    (host_ce_n),
        .sram_ce_n    (sram_ce_n),
        .guard_active (guard_active)
    );

    task automatic chk(input logic eo, input logic ep, input string tag);
        nchk++;
        if (sram_ce_n !== eo || guard_active !== ep) begin
            nbad++;
            $display("FAIL %s: sram_ce_n=%b guard_active=%b, expected %b %b",
                     tag, sram_ce_n, guard_active, eo, ep);
        end
    endtask

    task automatic cyc(input logic p, input logic c);
        @(negedge clk);
        pfail = p;
        host_ce_n = c;
        #1;
    endtask

    // R6: restore from a blocked state; high for samples 0..R, idle at R+1
    task automatic restore();
        for (int r = 0; r <= R + 1; r++) begin
            cyc(1'b0, 1'b0);
            chk((r <= R), (r <= R), "R6");
        end
    endtask

    initial begin
        #(4 * 50000);
        nbad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        // R7: during reset
        repeat (3) cyc(1'b0, 1'b0);
        chk(1'b1, 1'b1, "R7");
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(1'b1, 1'b1, "R7");
        for (int n = 1; n <= R + 3; n++) begin
            cyc(1'b0, 1'b0);
            chk((n <= R), (n <= R), "R7");
        end

        // R1: every 4-bit toggle pattern while idle
        for (int p = 0; p < 16; p++) begin
            for (int i = 0; i < 4; i++) begin
                cyc(1'b0, p[i]);
                chk(p[i], 1'b0, "R1");
            end
        end

        // R2 with R4: failure while the host is idle
        for (int h = 1; h <= 3; h++) begin
            cyc(1'b1, 1'b1);
            chk(1'b1, 1'b0, "R2");
            for (int m = 1; m <= h + D; m++) begin
                cyc(1'b1, m[0]);
                chk(1'b1, 1'b1, "R2");
            end
            restore();
        end

        // R3 / R4 / R5: release at every point of the grace window and beyond
        for (int k = 1; k <= D + 2; k++) begin
            cyc(1'b1, 1'b0);
            chk(1'b0, 1'b0, "R3");
            for (int m = 1; m <= D + 4; m++) begin
                int lim;
                lim = (k < D + 1) ? k : D + 1;
                cyc(1'b1, (m == k));
                chk((m >= lim), 1'b1, (k > D) ? "R5" : ((m > k) ? "R4" : "R3"));
            end
            restore();
        end

        // R8: reassert at each offset of the recovery interval
        for (int j = 1; j <= R; j++) begin
            cyc(1'b1, 1'b1);
            cyc(1'b1, 1'b0);
            chk(1'b1, 1'b1, "R8");
            for (int r = 0; r < j; r++) begin
                cyc(1'b0, 1'b0);
                chk(1'b1, 1'b1, "R8");
            end
            cyc(1'b1, 1'b0);
            chk(1'b1, 1'b1, "R8");
            cyc(1'b1, 1'b0);
            chk(1'b1, 1'b1, "R8");
            restore();
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule